// File: doc/BRIEF.md
# Two-Level Multiprocessor Interrupt Controller

This block collects 32 external interrupt lines into a shared system-level bank and hands the resulting requests to one selected processor, while each processor also owns a small bank of software-raised interrupt bits. For every processor it merges the routed external requests with that processor's soft requests and presents the highest active priority level, 1 to 15, as a registered 4-bit code (0 means idle).

Software reaches the banks through a plain word-addressed register port with separate read and write strobes. The address splits into a bank field (upper bits) and a 3-bit word offset (low bits). Banks `0 .. NUM_CPUS-1` are the per-processor banks, bank `NUM_CPUS` is the shared bank, and other bank values are ignored and read as zero. Read data is combinational and is zero whenever the read strobe is low. The register port has no back-pressure: every strobed access completes in the cycle it is presented.

The shared disable word has separate set and clear addresses, so no read-modify-write is ever needed. A fixed reserved pattern, 0x4FB2007F, can never be changed by software. Bit 31 of the disable word blocks all external routing at once.

Top module: `irqc_top`

## Requirements
- R1: After reset every level output is 0, the shared pending word and all soft words read 0, the disable word reads 0x4FB2007F and the target selector reads 0.
- R2: A write to per-processor offset 2 ORs (wdata & 0xFFFE0000) into that processor's soft word; other processors' soft words are unchanged.
- R3: A write to per-processor offset 1 clears the bits of (wdata & 0xFFFE0000) from that processor's soft word, with wdata bit 14 acting as an extra request to clear bit 31.
- R4: Shared reads return the pending word with bit 31 at 0 at offset 0, the disable word at offset 1, and the target selector zero-extended at offset 4; per-processor offset 0 returns that soft word; every other location reads 0.
- R5: A shared write at offset 2 clears the bits of (wdata & ~0x4FB2007F) in the disable word; reserved bits stay 1 forever.
- R6: A shared write at offset 3 sets the bits of (wdata & ~0x4FB2007F) in the disable word and clears them in the pending word; that clear wins over a line latching into the same bit in the same cycle.
- R7: Each cycle, external lines 0 to 30 are ORed into the pending word, where they stay until cleared by R6; line 31 is never latched.
- R8: A pending external bit j requests a level only when disable bit j is 0 and disable bit 31 is 0, and only at the processor whose index equals the target selector (written at shared offset 4).
- R9: Pending bit j requests level LEVEL_MAP[4j+3:4j]; entries of 0 request nothing. The default map is level = j mod 16.
- R10: Soft bits 17 to 31 of a processor request levels 1 to 15 (bit k requests level k-16) at that processor only.
- R11: Each level output holds the index of the highest requested level, or 0, computed from the register state of the previous cycle and registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | External interrupt lines, level sampled each cycle |
| bus_addr | input | ADDR_W (6) | Word address: bank in upper bits, offset in bits 2:0 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| cpu_level | output | NUM_CPUS*4 (16) | Per-processor level code, processor i in bits 4i+3:4i |

## Verification
The collision that matters is an external line rising into a pending bit in the very cycle software masks that bit through the disable-set address. The bench provokes this on purpose by holding a line high across the mask write, and then random traffic keeps lines asserted while writes hit the same bank. A behavioural model applies the latch and the clear in the required order, clear last. It compares the read-back pending word and all level outputs every cycle, so a design that lets the latch win shows a stale pending bit and a non-zero level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LVL_W  = 4;
  localparam int unsigned NUM_LVL = 16;

  localparam logic [WORD_W-1:0] RSVD_MASK = 32'h4FB2007F;
  localparam logic [WORD_W-1:0] WR_MASK   = ~RSVD_MASK;
  localparam logic [WORD_W-1:0] SOFT_MASK = 32'hFFFE0000;
  localparam int unsigned GDIS_BIT  = 31;
  localparam int unsigned ALIAS_BIT = 14;

  // Word offsets inside a bank
  localparam logic [2:0] OFS_READ0 = 3'd0;
  localparam logic [2:0] OFS_READ1 = 3'd1;
  localparam logic [2:0] OFS_CLR   = 3'd1;
  localparam logic [2:0] OFS_SET   = 3'd2;
  localparam logic [2:0] OFS_UNMSK = 3'd2;
  localparam logic [2:0] OFS_MSK   = 3'd3;
  localparam logic [2:0] OFS_TGT   = 3'd4;

  function automatic logic [WORD_W*LVL_W-1:0] default_level_map();
    logic [WORD_W*LVL_W-1:0] m;
    m = '0;
    for (int j = 0; j < WORD_W; j++) m[j*LVL_W +: LVL_W] = LVL_W'(j % NUM_LVL);
    return m;
  endfunction
endpackage

// File: rtl/irqc_shared.sv
module irqc_shared
  import irqc_pkg::*;
#(
  parameter int unsigned CPU_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] irq_in,
  input  logic              wr_en,
  input  logic [2:0]        ofs,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] dis_q,
  output logic [CPU_W-1:0]  tgt_q
);
  logic [WORD_W-1:0] wr_bits;
  logic [WORD_W-1:0] mask_clr;
  logic [WORD_W-1:0] line_bits;

  assign wr_bits   = wdata & WR_MASK;
  assign mask_clr  = (wr_en && ofs == OFS_MSK) ? wr_bits : '0;
  assign line_bits = irq_in & ~(WORD_W'(1) << GDIS_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      dis_q  <= RSVD_MASK;
      tgt_q  <= '0;
    end else begin
      // latch first, mask-clear last: the clear wins
      pend_q <= (pend_q | line_bits) & ~mask_clr;
      if (wr_en && ofs == OFS_UNMSK) dis_q <= dis_q & ~wr_bits;
      else if (wr_en && ofs == OFS_MSK) dis_q <= dis_q | wr_bits;
      if (wr_en && ofs == OFS_TGT) tgt_q <= wdata[CPU_W-1:0];
    end
  end

  assert_rsvd_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q & RSVD_MASK) == RSVD_MASK);

  assert_mask_clears_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_MSK) |=> (pend_q & $past(wr_bits)) == '0);

  assert_mask_sets_dis_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_MSK) |=> (dis_q & $past(wr_bits)) == $past(wr_bits));

  assert_line_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && ofs == OFS_MSK)) |=> (pend_q & $past(line_bits)) == $past(line_bits));
endmodule

// File: rtl/irqc_cpu_bank.sv
module irqc_cpu_bank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] soft_q
);
  logic [WORD_W-1:0] set_bits;
  logic [WORD_W-1:0] clr_bits;

  assign set_bits = wdata & SOFT_MASK;
  assign clr_bits = (wdata | (wdata[ALIAS_BIT] ? (WORD_W'(1) << GDIS_BIT) : '0)) & SOFT_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)      soft_q <= '0;
    else if (wr_set) soft_q <= soft_q | set_bits;
    else if (wr_clr) soft_q <= soft_q & ~clr_bits;
  end

  assert_soft_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (soft_q & $past(set_bits)) == $past(set_bits));

  assert_alias_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && wdata[ALIAS_BIT]) |=> !soft_q[GDIS_BIT]);

  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !wr_clr) |=> $stable(soft_q));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [NUM_LVL-1:0] req,
  output logic [LVL_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int k = 1; k < NUM_LVL; k++) if (req[k]) idx = LVL_W'(k);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4,
  parameter logic [WORD_W*LVL_W-1:0] LEVEL_MAP = irqc_pkg::default_level_map(),
  localparam int unsigned CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int unsigned BANK_W = $clog2(NUM_CPUS + 1),
  localparam int unsigned ADDR_W = BANK_W + 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WORD_W-1:0]         irq_in,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  output logic [NUM_CPUS*LVL_W-1:0] cpu_level
);
  logic [BANK_W-1:0] bank;
  logic [2:0]        ofs;
  logic              sh_wr;
  logic [WORD_W-1:0] pend_q, dis_q;
  logic [CPU_W-1:0]  tgt_q;
  logic [NUM_CPUS-1:0][WORD_W-1:0] soft_q;
  logic [WORD_W-1:0]  routed;
  logic [NUM_LVL-1:0] src_req;

  assign bank  = bus_addr[ADDR_W-1:3];
  assign ofs   = bus_addr[2:0];
  assign sh_wr = bus_wr && (bank == BANK_W'(NUM_CPUS));

  irqc_shared #(.CPU_W(CPU_W)) u_shared (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(sh_wr), .ofs(ofs),
    .wdata(bus_wdata), .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q)
  );

  assign routed = dis_q[GDIS_BIT] ? '0 : (pend_q & ~dis_q);

  always_comb begin
    src_req = '0;
    for (int j = 0; j < WORD_W; j++)
      if (routed[j]) src_req[LEVEL_MAP[j*LVL_W +: LVL_W]] = 1'b1;
    src_req[0] = 1'b0;
  end

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    logic               sel;
    logic [NUM_LVL-1:0] req;
    logic [LVL_W-1:0]   idx;
    logic [LVL_W-1:0]   lvl_q;

    assign sel = bus_wr && (bank == BANK_W'(i));

    irqc_cpu_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_set(sel && ofs == OFS_SET), .wr_clr(sel && ofs == OFS_CLR),
      .wdata(bus_wdata), .soft_q(soft_q[i])
    );

    assign req = ((tgt_q == CPU_W'(i)) ? src_req : '0)
               | (soft_q[i][WORD_W-1:NUM_LVL] & ~NUM_LVL'(1));

    irqc_prio u_prio (.req(req), .idx(idx));

    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= idx;
    end
    assign cpu_level[i*LVL_W +: LVL_W] = lvl_q;

    assert_gdis_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q[GDIS_BIT] && soft_q[i][WORD_W-1:17] == '0) |=> lvl_q == '0);

    assert_untargeted_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q != CPU_W'(i) && soft_q[i][WORD_W-1:17] == '0) |=> lvl_q == '0);

    assert_soft_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_q[i][GDIS_BIT] |=> lvl_q == 4'd15);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bank == BANK_W'(NUM_CPUS)) begin
        case (ofs)
          OFS_READ0: bus_rdata = pend_q & ~(WORD_W'(1) << GDIS_BIT);
          OFS_READ1: bus_rdata = dis_q;
          OFS_TGT:   bus_rdata = WORD_W'(tgt_q);
          default:   bus_rdata = '0;
        endcase
      end else begin
        for (int i = 0; i < NUM_CPUS; i++)
          if (bank == BANK_W'(i) && ofs == OFS_READ0) bus_rdata = soft_q[i];
      end
    end
  end
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_P = 10;
  localparam int NC = 4;
  localparam int SH = NC;  // shared bank index

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = 0;
  logic [5:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [15:0] cpu_level;

  irqc_top dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_level(cpu_level));

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit [31:0] m_pend, m_dis, m_soft[NC];
  int        m_tgt;
  int        m_exp[NC];

  function automatic int map_lvl(int j); return j % 16; endfunction

  function automatic int model_level(int c);
    int best = 0;
    for (int j = 0; j < 32; j++)
      if (!m_dis[31] && m_tgt == c && m_pend[j] && !m_dis[j] && map_lvl(j) > best)
        best = map_lvl(j);
    for (int k = 17; k < 32; k++)
      if (m_soft[c][k] && (k - 16) > best) best = k - 16;
    return best;
  endfunction

  function automatic bit [31:0] model_read(int bank, int ofs);
    if (bank == SH) begin
      if (ofs == 0) return m_pend & 32'h7FFFFFFF;
      if (ofs == 1) return m_dis;
      if (ofs == 4) return 32'(m_tgt);
      return 0;
    end
    if (bank < NC && ofs == 0) return m_soft[bank];
    return 0;
  endfunction

  task automatic check(string tag, bit [31:0] got, bit [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = 0; m_dis = 32'h4FB2007F; m_tgt = 0;
    for (int c = 0; c < NC; c++) begin m_soft[c] = 0; m_exp[c] = 0; end
  endtask

  task automatic model_step(bit wr, int bank, int ofs, bit [31:0] wd, bit [31:0] irq);
    bit [31:0] wb, clr;
    for (int c = 0; c < NC; c++) m_exp[c] = model_level(c);
    wb = wd & ~32'h4FB2007F;
    clr = (wr && bank == SH && ofs == 3) ? wb : 0;
    m_pend = (m_pend | (irq & 32'h7FFFFFFF)) & ~clr;
    if (wr && bank == SH && ofs == 2) m_dis &= ~wb;
    if (wr && bank == SH && ofs == 3) m_dis |= wb;
    if (wr && bank == SH && ofs == 4) m_tgt = wd & 3;
    if (wr && bank < NC && ofs == 2) m_soft[bank] |= wd & 32'hFFFE0000;
    if (wr && bank < NC && ofs == 1) begin
      bit [31:0] v = wd;
      if (v[14]) v[31] = 1;
      m_soft[bank] &= ~(v & 32'hFFFE0000);
    end
  endtask

  // one bus cycle; levels compared every cycle (R11), read data if reading
  task automatic cyc(string tag, bit wr, bit rd, int bank, int ofs, bit [31:0] wd, bit [31:0] irq);
    @(negedge clk);
    for (int c = 0; c < NC; c++)
      check("R11 level", 32'(cpu_level[c*4 +: 4]), 32'(m_exp[c]));
    bus_wr = wr; bus_rd = rd; bus_addr = 6'((bank << 3) | ofs);
    bus_wdata = wd; irq_in = irq;
    #1;
    if (rd) check(tag, bus_rdata, model_read(bank, ofs));
    else    check("R4 idle read zero", bus_rdata, 0);
    @(posedge clk);
    model_step(wr, bank, ofs, wd, irq);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset values
    cyc("R1 pend", 0, 1, SH, 0, 0, 0);
    cyc("R1 disable", 0, 1, SH, 1, 0, 0);
    check("R1 disable const", m_dis, 32'h4FB2007F);
    cyc("R1 target", 0, 1, SH, 4, 0, 0);
    cyc("R1 soft", 0, 1, 2, 0, 0, 0);
    // R7/R9: one-cycle pulse on line 8 sticks, level 8 at cpu0
    cyc("R7 pulse", 0, 0, 0, 0, 0, 32'h100);
    cyc("R7 sticky", 0, 1, SH, 0, 0, 0);
    cyc("R9 level", 0, 0, 0, 0, 0, 0);
    // R7: line 31 never latched
    cyc("R7 line31", 0, 0, 0, 0, 0, 32'h80000000);
    cyc("R7 no bit31", 0, 1, SH, 0, 0, 0);
    // R8: retarget to cpu2
    cyc("R8 tgt", 1, 0, SH, 4, 2, 0);
    cyc("R8 tgt rd", 0, 1, SH, 4, 0, 0);
    cyc("R8 move", 0, 0, 0, 0, 0, 0);
    // R6: mask bit 8 while line 8 still high: clear wins
    cyc("R6 collide", 1, 0, SH, 3, 32'h100, 32'h100);
    cyc("R6 pend", 0, 1, SH, 0, 0, 0);
    cyc("R6 dis", 0, 1, SH, 1, 0, 0);
    // R5: unmask everything writable; reserved stays
    cyc("R5 unmask", 1, 0, SH, 2, 32'hFFFFFFFF, 0);
    cyc("R5 dis", 0, 1, SH, 1, 0, 0);
    // R8 global: lines 9,10 pending then bit31 masks all routing
    cyc("R8 lines", 0, 0, 0, 0, 0, 32'h600);
    cyc("R8 gdis", 1, 0, SH, 3, 32'h80000000, 0);
    cyc("R8 gdis rd", 0, 1, SH, 1, 0, 0);
    cyc("R8 gdis", 0, 0, 0, 0, 0, 0);
    cyc("R5 ungdis", 1, 0, SH, 2, 32'h80000000, 0);
    // R2/R10: soft set on cpu1
    cyc("R2 set", 1, 0, 1, 2, 32'hFFFFFFFF, 0);
    cyc("R2 soft", 0, 1, 1, 0, 0, 0);
    cyc("R10 level15", 0, 1, 0, 0, 0, 0);
    // R3: bit14 alias clears bit 31 only
    cyc("R3 alias", 1, 0, 1, 1, 32'h00004000, 0);
    cyc("R3 soft", 0, 1, 1, 0, 0, 0);
    cyc("R3 level", 0, 0, 0, 0, 0, 0);
    cyc("R3 clr all", 1, 0, 1, 1, 32'hFFFFFFFF, 0);
    cyc("R3 soft0", 0, 1, 1, 0, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int bank = $urandom_range(0, 5);
      int ofs  = $urandom_range(0, 5);
      bit wr   = ($urandom_range(0, 2) == 0);
      bit [31:0] wd = $urandom;
      bit [31:0] irq = $urandom & $urandom & $urandom;
      if ($urandom_range(0, 3) == 0) wd[14] = 1;
      cyc("R4 random", wr, !wr, bank, ofs, wd, irq);
    end
    cyc("R11 tail", 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule